// File: doc/BRIEF.md
# Configurable UART Frame Transmitter

This block serialises one character per start request onto an asynchronous serial line. The framing is chosen at run time. A frame carries 7, 8 or 9 data bits, least significant bit first. In the 7- and 8-bit lengths an optional parity bit of one of four kinds can follow the data. The frame closes with one or two stop bits, and the final stop bit can be cut to seven eighths of its normal length. The line rests high between frames.

The block has no baud generator of its own. It is paced by an external tick at sixteen times the bit rate, so each full bit lasts sixteen ticks. A shortened stop bit lasts fourteen ticks. When a start request arrives while the block is idle, the block captures the data byte and the whole configuration at once. Changes to those inputs during the frame have no effect on that frame.

The two-bit parity-type field has two roles. Its low bit is the ninth data bit in 9-bit mode, and a parity-type bit in the other lengths.

Top module: `uart_frame_tx`

## Requirements
- R1: While busy is low, including after reset, the serial line is high and busy is low.
- R2: A start request seen while idle raises busy at the next clock edge, and the line drives the low start bit from that edge onward.
- R3: The length code selects the data length: 00 gives 8 bits, 01 gives 7 bits (data bits 6..0), and 10 or 11 gives 9 bits. Data is sent least significant bit first, right after the start bit.
- R4: With parity enabled and a length of 7 or 8, one parity bit follows the data. The type code sets its value: 00 odd, 01 mark (always 1), 10 even, 11 space (always 0). Odd and even are computed over the data bits actually sent.
- R5: In 9-bit mode, all eight bits of the data byte are sent, followed by bit 0 of the parity-type field as the ninth bit. No parity bit is sent, even when parity is enabled.
- R6: One stop bit is sent when the two-stop control is 0, and two when it is 1. Stop bits are high.
- R7: Every bit lasts 16 baud ticks. When short-stop is set, only the last stop bit is cut, and it lasts 14 ticks.
- R8: Busy falls at the clock edge that consumes the last tick of the final stop bit. The frame therefore spans exactly 16·N ticks, or 16·N−2 ticks with short-stop, where N is the bit count.
- R9: A start request while busy is ignored. It starts no extra frame and does not alter the frame in progress.
- R10: Data and configuration are captured with the accepted start request. Changing them during a frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_data | input | 8 | Character to send |
| cfg_len | input | 2 | Data length code |
| cfg_par_en | input | 1 | Parity enable |
| cfg_par_sel | input | 2 | Parity type; bit 0 is the ninth data bit in 9-bit mode |
| cfg_two_stop | input | 1 | Two stop bits when 1 |
| cfg_short_stop | input | 1 | Cut the final stop bit to 7/8 of a bit |
| baud_tick | input | 1 | One-cycle pulse at 16× the bit rate |
| start | input | 1 | Request to send a frame |
| tx_line | output | 1 | Serial output, idles high |
| busy | output | 1 | High while a frame is being sent |

## Verification
Faults in the internal state show at the ports within one frame. A wrong bit index or a wrong captured bit count shows as a wrong level at a bit centre, eight ticks into the affected bit. A wrong tick count shows as a frame whose total tick span differs from 16·N, or from 16·N−2, at the moment busy falls. A broken idle guard shows as an unexpected frame, or as a frame whose bits change halfway through, within the same character time.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    localparam int TICKS_PER_BIT = 16;
    localparam int SHORT_TICKS   = (TICKS_PER_BIT * 7) / 8;
    localparam int MAX_BITS      = 12;
    localparam int IDX_W         = $clog2(MAX_BITS);

    typedef enum logic [1:0] {
        LEN_8  = 2'b00,
        LEN_7  = 2'b01,
        LEN_9  = 2'b10,
        LEN_9B = 2'b11
    } len_e;

    typedef enum logic [1:0] {
        PAR_ODD   = 2'b00,
        PAR_MARK  = 2'b01,
        PAR_EVEN  = 2'b10,
        PAR_SPACE = 2'b11
    } par_e;

    typedef struct packed {
        logic [MAX_BITS-1:0] bits;
        logic [IDX_W-1:0]    last;
        logic                short_end;
    } frame_t;

    function automatic int data_len(input len_e len);
        case (len)
            LEN_7:   return 7;
            LEN_8:   return 8;
            default: return 9;
        endcase
    endfunction

    function automatic frame_t build_frame(
        input logic [7:0] data,
        input len_e       len,
        input logic       par_en,
        input logic [1:0] par_sel,
        input logic       two_stop,
        input logic       short_stop
    );
        frame_t f;
        int     nd;
        int     nb;
        logic   ones;
        logic   pbit;
        nd     = data_len(len);
        f.bits = '1;
        f.bits[0] = 1'b0;
        ones   = 1'b0;
        for (int i = 0; i < 9; i++) begin
            if (i < nd) begin
                if (i == 8) begin
                    f.bits[1 + i] = par_sel[0];
                end else begin
                    f.bits[1 + i] = data[i];
                    ones = ones ^ data[i];
                end
            end
        end
        nb = 1 + nd;
        if (par_en && nd != 9) begin
            case (par_e'(par_sel))
                PAR_ODD:   pbit = ~ones;
                PAR_MARK:  pbit = 1'b1;
                PAR_EVEN:  pbit = ones;
                default:   pbit = 1'b0;
            endcase
            f.bits[nb] = pbit;
            nb = nb + 1;
        end
        nb = nb + (two_stop ? 2 : 1);
        f.last      = IDX_W'(nb - 1);
        f.short_end = short_stop;
        return f;
    endfunction

endpackage

// File: rtl/uart_tx_timer.sv
module uart_tx_timer
    import uart_tx_pkg::*;
#(
    parameter int FULL_TICKS = TICKS_PER_BIT,
    parameter int CUT_TICKS  = SHORT_TICKS
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic tick,
    input  logic cut_bit,
    output logic bit_done
);
    localparam int CW = $clog2(FULL_TICKS);
    localparam logic [CW-1:0] FULL_LAST = CW'(FULL_TICKS - 1);
    localparam logic [CW-1:0] CUT_LAST  = CW'(CUT_TICKS - 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;

    always_comb begin
        lim      = cut_bit ? CUT_LAST : FULL_LAST;
        bit_done = run && tick && (cnt == lim);
    end

    always_ff @(posedge clk) begin
        if (rst || !run || bit_done) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + 1'b1;
        end
    end

    assert_tick_bound_R7: assert property (@(posedge clk) disable iff (rst)
        cut_bit |-> (cnt <= CUT_LAST));

endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter
    import uart_tx_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic [MAX_BITS-1:0] bits_in,
    input  logic                shift,
    output logic                line,
    output logic [IDX_W-1:0]    idx
);
    logic [MAX_BITS-1:0] sreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg <= '1;
            idx  <= '0;
        end else if (load) begin
            sreg <= bits_in;
            idx  <= '0;
        end else if (shift) begin
            sreg <= {1'b1, sreg[MAX_BITS-1:1]};
            idx  <= idx + 1'b1;
        end
    end

    assign line = sreg[0];

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
    import uart_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] tx_data,
    input  logic [1:0] cfg_len,
    input  logic       cfg_par_en,
    input  logic [1:0] cfg_par_sel,
    input  logic       cfg_two_stop,
    input  logic       cfg_short_stop,
    input  logic       baud_tick,
    input  logic       start,
    output logic       tx_line,
    output logic       busy
);
    frame_t           frm_next;
    logic [IDX_W-1:0] last_q;
    logic             short_q;
    logic [IDX_W-1:0] idx;
    logic             load;
    logic             at_last;
    logic             bit_done;
    logic             frame_done;

    always_comb begin
        frm_next   = build_frame(tx_data, len_e'(cfg_len), cfg_par_en,
                                 cfg_par_sel, cfg_two_stop, cfg_short_stop);
        load       = start && !busy;
        at_last    = (idx == last_q);
        frame_done = bit_done && at_last;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            last_q  <= '0;
            short_q <= 1'b0;
        end else if (load) begin
            busy    <= 1'b1;
            last_q  <= frm_next.last;
            short_q <= frm_next.short_end;
        end else if (frame_done) begin
            busy    <= 1'b0;
        end
    end

    uart_tx_timer u_timer (
        .clk      (clk),
        .rst      (rst),
        .run      (busy),
        .tick     (baud_tick),
        .cut_bit  (short_q && at_last),
        .bit_done (bit_done)
    );

    uart_tx_shifter u_shift (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .bits_in (frm_next.bits),
        .shift   (bit_done),
        .line    (tx_line),
        .idx     (idx)
    );

    assert_idle_high_R1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> tx_line);

    assert_start_low_R2: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (busy && !tx_line));

    assert_last_is_stop_R6: assert property (@(posedge clk) disable iff (rst)
        (busy && at_last) |-> tx_line);

    assert_end_on_tick_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(baud_tick));

    assert_hold_frame_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && start && !frame_done) |=> (busy && $stable(last_q)));

endmodule

// File: tb/uart_frame_tx_tb_top.sv
module uart_frame_tx_tb_top;

    typedef struct {
        logic [15:0] bits;
        int          n;
        int          total;
        string       tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] tx_data = 8'h00;
    logic [1:0] cfg_len = 2'b00;
    logic       cfg_par_en = 1'b0;
    logic [1:0] cfg_par_sel = 2'b00;
    logic       cfg_two_stop = 1'b0;
    logic       cfg_short_stop = 1'b0;
    logic       baud_tick = 1'b0;
    logic       start = 1'b0;
    logic       tx_line;
    logic       busy;

    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;
    exp_t sb[$];

    always #10 clk = ~clk;

    uart_frame_tx dut_i (
        .clk(clk), .rst(rst), .tx_data(tx_data), .cfg_len(cfg_len),
        .cfg_par_en(cfg_par_en), .cfg_par_sel(cfg_par_sel),
        .cfg_two_stop(cfg_two_stop), .cfg_short_stop(cfg_short_stop),
        .baud_tick(baud_tick), .start(start), .tx_line(tx_line), .busy(busy)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            #1 baud_tick <= 1'b1;
            @(posedge clk);
            #1 baud_tick <= 1'b0;
            @(posedge clk);
        end
    end

    function automatic exp_t model(input logic [7:0] d, input logic [1:0] len,
                                   input logic pen, input logic [1:0] ps,
                                   input logic two, input logic shrt, input string tag);
        exp_t e;
        int   nd;
        int   pos;
        logic par;
        nd = (len == 2'b01) ? 7 : (len == 2'b00) ? 8 : 9;
        e.bits = 16'hFFFF;
        e.bits[0] = 1'b0;
        par = 1'b0;
        for (int i = 0; i < nd; i++) begin
            e.bits[1 + i] = (i < 8) ? d[i] : ps[0];
            if (i < 8) par = par ^ d[i];
        end
        pos = 1 + nd;
        if (pen && nd < 9) begin
            if (ps == 2'b00)      e.bits[pos] = ~par;
            else if (ps == 2'b10) e.bits[pos] = par;
            else if (ps == 2'b01) e.bits[pos] = 1'b1;
            else                  e.bits[pos] = 1'b0;
            pos++;
        end
        e.n     = pos + (two ? 2 : 1);
        e.total = 16 * e.n - (shrt ? 2 : 0);
        e.tag   = tag;
        return e;
    endfunction

    task automatic send(input logic [7:0] d, input logic [1:0] len, input logic pen,
                        input logic [1:0] ps, input logic two, input logic shrt,
                        input bit disturb, input string tag);
        while (busy) @(posedge clk);
        @(posedge clk);
        #2;
        tx_data = d; cfg_len = len; cfg_par_en = pen; cfg_par_sel = ps;
        cfg_two_stop = two; cfg_short_stop = shrt; start = 1'b1;
        sb.push_back(model(d, len, pen, ps, two, shrt, tag));
        @(posedge clk);
        #2 start = 1'b0;
        if (disturb) begin
            repeat (100) @(posedge clk);
            #2;
            tx_data = ~d; cfg_len = 2'b01; cfg_par_en = 1'b1; cfg_par_sel = ~ps;
            cfg_two_stop = ~two; cfg_short_stop = ~shrt; start = 1'b1;
            @(posedge clk);
            #2 start = 1'b0;
            repeat (150) @(posedge clk);
            #2 start = 1'b1;
            @(posedge clk);
            #2 start = 1'b0;
        end
        while (!busy) @(posedge clk);
        while (busy) @(posedge clk);
    endtask

    initial begin
        bit   in_frame;
        int   cnt;
        int   k;
        exp_t cur;
        in_frame = 1'b0;
        cnt = 0;
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (busy && !in_frame) begin
                    in_frame = 1'b1;
                    cnt = 0;
                    if (sb.size() == 0) begin
                        chk(1'b0, "R9 unexpected frame", 1, 0);
                        cur = model(8'h00, 2'b00, 1'b0, 2'b00, 1'b0, 1'b0, "R9");
                    end else begin
                        cur = sb.pop_front();
                    end
                    chk(tx_line == 1'b0, {"R2 start bit ", cur.tag}, int'(tx_line), 0);
                end
                if (in_frame) begin
                    if (!busy) begin
                        chk(cnt == cur.total, {"R8 tick span ", cur.tag}, cnt, cur.total);
                        chk(tx_line == 1'b1, {"R1 idle after ", cur.tag}, int'(tx_line), 1);
                        in_frame = 1'b0;
                    end else if (baud_tick) begin
                        cnt++;
                        if (cnt % 16 == 8) begin
                            k = cnt / 16;
                            if (k < cur.n)
                                chk(tx_line == cur.bits[k], {"bit ", cur.tag},
                                    int'(tx_line), int'(cur.bits[k]));
                        end
                    end
                end
            end
        end
    end

    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        @(negedge clk);
        chk(tx_line == 1'b1, "R1 reset line", int'(tx_line), 1);
        chk(busy == 1'b0, "R1 reset busy", int'(busy), 0);

        send(8'hA5, 2'b00, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, "R3 8bit");
        send(8'hC3, 2'b01, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, "R3 7bit");
        send(8'h07, 2'b00, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0, "R4 odd");
        send(8'h07, 2'b00, 1'b1, 2'b10, 1'b0, 1'b0, 1'b0, "R4 even");
        send(8'hC0, 2'b01, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0, "R4 odd7");
        send(8'h00, 2'b01, 1'b1, 2'b01, 1'b0, 1'b0, 1'b0, "R4 mark");
        send(8'hFF, 2'b00, 1'b1, 2'b11, 1'b0, 1'b0, 1'b0, "R4 space");
        send(8'h3C, 2'b10, 1'b1, 2'b01, 1'b0, 1'b0, 1'b0, "R5 nine1");
        send(8'hF0, 2'b11, 1'b1, 2'b10, 1'b0, 1'b0, 1'b0, "R5 nine0");
        send(8'h5A, 2'b00, 1'b0, 2'b00, 1'b1, 1'b0, 1'b0, "R6 two stop");
        send(8'h96, 2'b00, 1'b1, 2'b10, 1'b0, 1'b1, 1'b0, "R7 short one");
        send(8'h69, 2'b10, 1'b0, 2'b01, 1'b1, 1'b1, 1'b0, "R7 short two");
        send(8'h12, 2'b00, 1'b0, 2'b00, 1'b0, 1'b0, 1'b1, "R9 R10 disturb");

        repeat (200) @(posedge clk);
        @(negedge clk);
        chk(sb.size() == 0, "R9 queue drained", sb.size(), 0);
        chk(busy == 1'b0, "R9 no extra frame", int'(busy), 0);
        chk(tx_line == 1'b1, "R1 final idle", int'(tx_line), 1);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule